// File: doc/BRIEF.md
# Coprocessor Bus Slave Interface

This block sits on the coprocessor side of a synchronous 32-bit host bus. It follows every host bus cycle, including cycles meant for other devices. It does this from the address strobe (`ads_n`) and the shared, wired ready line (`rdy_n`). At the strobe clock it samples the direction, the space select, the address and the chip enable. It accepts a cycle only when that cycle is an I/O access to one of the two coprocessor ports. For each accepted cycle it drives one active-low ready-out clock. A write therefore completes in two clocks and a read in three.

The host ready line is the AND of this block's ready-out and the ready outputs of other devices. Because of this, the block closes its cycle tracking on whichever ready ends the cycle. It also reports which port a cycle targets and raises an error pulse if the host asks for 16-bit bus sizing during a coprocessor cycle. The chip-enable input floats the block's output drivers when it is low.

The tracker has four states:
- `ST_IDLE`: waiting for a strobe.
- `ST_RD_WAIT`: the single wait clock of a read.
- `ST_ACK`: the clock that drives ready-out.
- `ST_TRACK`: waiting for the shared ready to close a cycle.

Its transitions are:
- From `ST_IDLE`, a strobe goes to `ST_ACK` (accepted write), to `ST_RD_WAIT` (accepted read) or to `ST_TRACK` (any other cycle).
- From `ST_RD_WAIT`, the next clock goes to `ST_ACK`. If shared ready is low, it goes to `ST_IDLE` instead.
- From `ST_ACK`, shared ready low goes to `ST_IDLE`. Otherwise it goes to `ST_TRACK`.
- From `ST_TRACK`, shared ready low goes to `ST_IDLE`.

Top module: `cop_bus_slave`

## Requirements
- R1: While `rst` is high, and in the clock after it is released, `rdyo_n` is 1, `data_oe` is 0 and `size_err` is 0.
- R2: A cycle is accepted only when, at the strobe clock, `mio_n` is 0 (I/O space), `addr` is 0x800000F8 or 0x800000FC and `sten` is 1. Any other cycle never drives `rdyo_n` low.
- R3: For an accepted write (`wr_rd` = 1 at the strobe clock), `rdyo_n` is low in the clock right after the strobe clock. That is clock 2, counting the strobe clock as 1.
- R4: For an accepted read (`wr_rd` = 0), `rdyo_n` is high in clock 2 and low in clock 3.
- R5: `rdyo_n` is low for exactly one clock per accepted cycle.
- R6: Every cycle closes on the clock in which shared `rdy_n` is low, whichever device drove it. A read closed early by another device's ready gets no ready-out. After any cycle closes, the next strobe is accepted normally.
- R7: A strobe that arrives while a cycle is still open, before shared ready closes it, is ignored.
- R8: When `sten` is 0, `rdyo_oe` and `data_oe` are 0 and `rdyo_n` is 1 in that same clock, with no register delay.
- R9: `data_oe` is 1 in clocks 2 and 3 of an accepted read while `sten` is 1. It is 0 in the clock after the read closes, and 0 throughout writes.
- R10: `port_sel` becomes 0 for port 0x800000F8 and 1 for port 0x800000FC from clock 2 of an accepted cycle. It holds that value through cycles that are not accepted.
- R11: If `bs16_n` is 0 in clock 2 or 3 of an accepted cycle, before ready closes it, `size_err` is 1 in the following clock only. Otherwise `size_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-frequency system clock; the host bus is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| ads_n | input | 1 | Host address strobe, active low |
| rdy_n | input | 1 | Shared host ready line, active low |
| wr_rd | input | 1 | Direction: 1 write to coprocessor, 0 read |
| mio_n | input | 1 | Space select: 0 I/O, 1 memory |
| addr | input | 32 | Host byte address |
| sten | input | 1 | Chip enable; low floats all outputs |
| bs16_n | input | 1 | Host 16-bit bus size request, active low |
| rdyo_n | output | 1 | Ready-out, active low |
| rdyo_oe | output | 1 | Driver enable for ready-out |
| data_oe | output | 1 | Driver enable for the read data bus |
| port_sel | output | 1 | Port targeted by the last accepted cycle |
| size_err | output | 1 | One-clock pulse on a bus-sizing violation |

## Verification
The hardest situation to create is a strobe arriving while the tracker is still inside a cycle that belongs to another device. That needs a cycle the block does not own, held open by a slow external ready. The bench builds it by issuing a non-decoded I/O cycle whose external ready comes only in clock 6. In clock 3 it places a second strobe that is a perfectly valid write to port 0x800000F8. It then checks that no ready-out appears, and that an identical write issued straight after the close is acknowledged normally. A read closed early by external ready is exercised in the same way.

// File: rtl/cop_bus_pkg.sv
package cop_bus_pkg;

    // Bus cycle tracker states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_ACK     = 2'd2,
        ST_TRACK   = 2'd3
    } cyc_state_t;

    // Host address width and coprocessor port map
    localparam int unsigned HOST_ADDR_W  = 32;
    localparam int unsigned COP_PORTS    = 2;
    localparam logic [31:0] COP_BASE     = 32'h8000_00F8;
    localparam int unsigned COP_STRIDE   = 4;

endpackage

// File: rtl/cop_addr_decode.sv
module cop_addr_decode #(
    parameter int unsigned ADDR_W    = cop_bus_pkg::HOST_ADDR_W,
    parameter int unsigned NUM_PORTS = cop_bus_pkg::COP_PORTS,
    parameter logic [ADDR_W-1:0] BASE = cop_bus_pkg::COP_BASE,
    parameter int unsigned STRIDE    = cop_bus_pkg::COP_STRIDE,
    localparam int unsigned PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mio_n,
    output logic              hit,
    output logic [PSEL_W-1:0] port_idx
);

    logic [NUM_PORTS-1:0] match;

    // One comparator per coprocessor port
    genvar g;
    generate
        for (g = 0; g < NUM_PORTS; g++) begin : g_port
            localparam logic [ADDR_W-1:0] PORT_ADDR =
                BASE + ADDR_W'(g * STRIDE);
            assign match[g] = (addr == PORT_ADDR) && !mio_n;
        end
    endgenerate

    assign hit = |match;

    // Encode the matching port to an index
    always_comb begin
        port_idx = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (match[i]) begin
                port_idx = PSEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/cop_cycle_fsm.sv
module cop_cycle_fsm #(
    parameter int unsigned PSEL_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_n,
    input  logic              rdy_n,
    input  logic              wr_rd,
    input  logic              sel_ok,
    input  logic [PSEL_W-1:0] port_in,
    output logic              ack_n,
    output logic              in_cyc,
    output logic              rd_phase,
    output logic [PSEL_W-1:0] port_q
);
    import cop_bus_pkg::*;

    cyc_state_t state, state_nx;
    logic       rd_q;

    wire start = (state == ST_IDLE) && !ads_n;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!ads_n) begin
                    if (!sel_ok)    state_nx = ST_TRACK;
                    else if (wr_rd) state_nx = ST_ACK;
                    else            state_nx = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: state_nx = rdy_n ? ST_ACK : ST_IDLE;
            ST_ACK:     state_nx = rdy_n ? ST_TRACK : ST_IDLE;
            ST_TRACK:   state_nx = rdy_n ? ST_TRACK : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register and per-cycle attributes latched at the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            rd_q   <= 1'b0;
            port_q <= '0;
        end else begin
            state <= state_nx;
            if (start && sel_ok) begin
                rd_q   <= !wr_rd;
                port_q <= port_in;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        ack_n    = (state != ST_ACK);
        in_cyc   = (state == ST_RD_WAIT) || (state == ST_ACK);
        rd_phase = in_cyc && rd_q;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (ack_n && !rd_phase));

    assert_unselected_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !sel_ok) |=> ack_n);

    assert_write_zero_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (start && sel_ok && wr_rd) |=> !ack_n);

    assert_read_first_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (start && sel_ok && !wr_rd) |=> ack_n);

    assert_read_ack_after_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_WAIT && rdy_n) |=> !ack_n);

    assert_single_ack_R5: assert property (@(posedge clk) disable iff (rst)
        !ack_n |=> ack_n);

    assert_ready_closes_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && !rdy_n) |=> (state == ST_IDLE));

    assert_ignore_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRACK && rdy_n) |=> (state == ST_TRACK));

endmodule

// File: rtl/cop_size_check.sv
module cop_size_check (
    input  logic clk,
    input  logic rst,
    input  logic in_cyc,
    input  logic bs16_n,
    output logic size_err
);

    always_ff @(posedge clk) begin
        if (rst) size_err <= 1'b0;
        else     size_err <= in_cyc && !bs16_n;
    end

    assert_err_raise_R11: assert property (@(posedge clk) disable iff (rst)
        (in_cyc && !bs16_n) |=> size_err);

    assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!in_cyc || bs16_n) |=> !size_err);

endmodule

// File: rtl/cop_bus_slave.sv
module cop_bus_slave #(
    parameter int unsigned ADDR_W    = cop_bus_pkg::HOST_ADDR_W,
    parameter int unsigned NUM_PORTS = cop_bus_pkg::COP_PORTS,
    parameter logic [ADDR_W-1:0] BASE = cop_bus_pkg::COP_BASE,
    parameter int unsigned STRIDE    = cop_bus_pkg::COP_STRIDE,
    localparam int unsigned PSEL_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ads_n,
    input  logic              rdy_n,
    input  logic              wr_rd,
    input  logic              mio_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sten,
    input  logic              bs16_n,
    output logic              rdyo_n,
    output logic              rdyo_oe,
    output logic              data_oe,
    output logic [PSEL_W-1:0] port_sel,
    output logic              size_err
);

    logic              hit;
    logic [PSEL_W-1:0] port_idx;
    logic              ack_n;
    logic              in_cyc;
    logic              rd_phase;

    cop_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_PORTS (NUM_PORTS),
        .BASE      (BASE),
        .STRIDE    (STRIDE)
    ) u_decode (
        .addr     (addr),
        .mio_n    (mio_n),
        .hit      (hit),
        .port_idx (port_idx)
    );

    cop_cycle_fsm #(
        .PSEL_W (PSEL_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ads_n    (ads_n),
        .rdy_n    (rdy_n),
        .wr_rd    (wr_rd),
        .sel_ok   (hit && sten),
        .port_in  (port_idx),
        .ack_n    (ack_n),
        .in_cyc   (in_cyc),
        .rd_phase (rd_phase),
        .port_q   (port_sel)
    );

    cop_size_check u_size (
        .clk      (clk),
        .rst      (rst),
        .in_cyc   (in_cyc),
        .bs16_n   (bs16_n),
        .size_err (size_err)
    );

    // Chip enable gates every driver without a register stage
    assign rdyo_oe = sten;
    assign rdyo_n  = ack_n || !sten;
    assign data_oe = rd_phase && sten;

    always_comb begin
        if (!sten) begin
            assert_float_R8: assert (!rdyo_oe && !data_oe && rdyo_n);
        end
    end

endmodule

// File: tb/cop_bus_slave_tb_top.sv
module cop_bus_slave_tb_top;

    typedef struct {
        int   clk_no;
        logic ps;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ads_n = 1'b1;
    logic        ext_rdy_n = 1'b1;
    logic        wr_rd = 1'b0;
    logic        mio_n = 1'b1;
    logic [31:0] addr = '0;
    logic        sten = 1'b1;
    logic        bs16_n = 1'b1;
    logic        rdyo_n, rdyo_oe, data_oe, size_err;
    logic [0:0]  port_sel;
    logic        rdy_n;

    int   tests = 0;
    int   fails = 0;
    int   cur_clk = 0;
    int   acks = 0;
    logic oe_log  [1:10];
    logic err_log [1:10];
    logic roe_log [1:10];
    exp_t exp_q [$];

    always #10 clk = ~clk;

    // Shared wired ready: pulled high when ready-out floats
    assign rdy_n = (rdyo_oe ? rdyo_n : 1'b1) & ext_rdy_n;

    cop_bus_slave dut_i (
        .clk      (clk),
        .rst      (rst),
        .ads_n    (ads_n),
        .rdy_n    (rdy_n),
        .wr_rd    (wr_rd),
        .mio_n    (mio_n),
        .addr     (addr),
        .sten     (sten),
        .bs16_n   (bs16_n),
        .rdyo_n   (rdyo_n),
        .rdyo_oe  (rdyo_oe),
        .data_oe  (data_oe),
        .port_sel (port_sel),
        .size_err (size_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected acknowledge whenever ready-out is seen
    always @(negedge clk) begin
        #2;
        if (!rst && !rdyo_n) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected ready-out at clock", cur_clk, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(cur_clk == e.clk_no, (e.clk_no == 2) ? "R3" : "R4",
                    "ready-out clock", cur_clk, e.clk_no);
                chk(port_sel == e.ps, "R10", "port_sel", int'(port_sel), int'(e.ps));
            end
        end
    end

    // Driver: one host bus cycle; clock 1 is the strobe clock
    task automatic run_cycle(input logic [31:0] a, input logic io, input logic w,
                             input logic se, input int bs_clk, input int ext_clk,
                             input int exp_ack, input logic exp_ps,
                             input int ads2_clk, input int drop_clk);
        exp_t e;
        acks = 0;
        for (int i = 1; i <= 10; i++) begin
            oe_log[i] = 1'b0; err_log[i] = 1'b0; roe_log[i] = 1'b0;
        end
        if (exp_ack != 0) begin
            e.clk_no = exp_ack;
            e.ps = exp_ps;
            exp_q.push_back(e);
        end
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            cur_clk   = k;
            ads_n     = !(k == 1 || k == ads2_clk);
            addr      = (k == ads2_clk) ? 32'h8000_00F8 : a;
            wr_rd     = (k == ads2_clk) ? 1'b1 : w;
            mio_n     = (k == ads2_clk) ? 1'b0 : io;
            sten      = (drop_clk != 0 && k >= drop_clk) ? 1'b0 : se;
            bs16_n    = !(k == bs_clk);
            ext_rdy_n = !(k == ext_clk);
            #1;
            oe_log[k]  = data_oe;
            err_log[k] = size_err;
            roe_log[k] = rdyo_oe;
            if (!rdyo_n) acks++;
            if (k > 1 && !rdy_n) break;
        end
        @(negedge clk);
        cur_clk = 0;
        ads_n = 1'b1; ext_rdy_n = 1'b1; bs16_n = 1'b1; sten = 1'b1;
        mio_n = 1'b1; addr = '0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: values while in reset
        chk(rdyo_n == 1'b1, "R1", "rdyo_n in reset", int'(rdyo_n), 1);
        chk(data_oe == 1'b0, "R1", "data_oe in reset", int'(data_oe), 0);
        chk(size_err == 1'b0, "R1", "size_err in reset", int'(size_err), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(rdyo_n == 1'b1 && data_oe == 1'b0 && size_err == 1'b0, "R1",
            "outputs after reset", int'({rdyo_n, data_oe, size_err}), 4);

        // R3 / R10: write to port 0
        run_cycle(32'h8000_00F8, 1'b0, 1'b1, 1'b1, 0, 0, 2, 1'b0, 0, 0);
        chk(acks == 1, "R5", "ready-out clocks on write", acks, 1);
        chk(rdyo_n == 1'b1, "R5", "ready-out released after write", int'(rdyo_n), 1);
        chk(oe_log[2] == 1'b0, "R9", "data_oe on write", int'(oe_log[2]), 0);
        chk(err_log[2] == 1'b0 && size_err == 1'b0, "R11", "no size error", int'(size_err), 0);

        // R4 / R9 / R10: read from port 1
        run_cycle(32'h8000_00FC, 1'b0, 1'b0, 1'b1, 0, 0, 3, 1'b1, 0, 0);
        chk(acks == 1, "R5", "ready-out clocks on read", acks, 1);
        chk(oe_log[2] == 1'b1, "R9", "data_oe read clock 2", int'(oe_log[2]), 1);
        chk(oe_log[3] == 1'b1, "R9", "data_oe read clock 3", int'(oe_log[3]), 1);
        chk(data_oe == 1'b0, "R9", "data_oe after read", int'(data_oe), 0);

        // R11: bus-size request during read clock 2
        run_cycle(32'h8000_00F8, 1'b0, 1'b0, 1'b1, 2, 0, 3, 1'b0, 0, 0);
        chk(err_log[2] == 1'b0, "R11", "size_err before violation", int'(err_log[2]), 0);
        chk(err_log[3] == 1'b1, "R11", "size_err pulse", int'(err_log[3]), 1);
        chk(size_err == 1'b0, "R11", "size_err single clock", int'(size_err), 0);

        // R2 / R10: write to port 1, then a non-decoded I/O address
        run_cycle(32'h8000_00FC, 1'b0, 1'b1, 1'b1, 0, 0, 2, 1'b1, 0, 0);
        run_cycle(32'h8000_00F0, 1'b0, 1'b1, 1'b1, 0, 3, 0, 1'b0, 0, 0);
        chk(acks == 0, "R2", "ready-out for other address", acks, 0);
        chk(port_sel == 1'b1, "R10", "port_sel held", int'(port_sel), 1);

        // R2: memory-space access at the port address
        run_cycle(32'h8000_00F8, 1'b1, 1'b1, 1'b1, 0, 2, 0, 1'b0, 0, 0);
        chk(acks == 0, "R2", "ready-out for memory cycle", acks, 0);

        // R8 / R2: chip enable low at strobe
        run_cycle(32'h8000_00F8, 1'b0, 1'b1, 1'b0, 0, 2, 0, 1'b0, 0, 0);
        chk(acks == 0, "R2", "ready-out while disabled", acks, 0);
        chk(roe_log[1] == 1'b0, "R8", "rdyo_oe while disabled", int'(roe_log[1]), 0);

        // R7: valid strobe inside a long foreign cycle
        run_cycle(32'h8000_00F0, 1'b0, 1'b1, 1'b1, 0, 6, 0, 1'b0, 3, 0);
        chk(acks == 0, "R7", "ready-out for nested strobe", acks, 0);
        // R6: next strobe after the foreign close is accepted
        run_cycle(32'h8000_00F8, 1'b0, 1'b1, 1'b1, 0, 0, 2, 1'b0, 0, 0);
        chk(acks == 1, "R6", "write after foreign cycle", acks, 1);

        // R6: read closed early by an external ready
        run_cycle(32'h8000_00F8, 1'b0, 1'b0, 1'b1, 0, 2, 0, 1'b0, 0, 0);
        chk(acks == 0, "R6", "ready-out on early-closed read", acks, 0);
        run_cycle(32'h8000_00FC, 1'b0, 1'b0, 1'b1, 0, 0, 3, 1'b1, 0, 0);
        chk(acks == 1, "R6", "read after early close", acks, 1);

        // R8: chip enable drops in the middle of a read
        run_cycle(32'h8000_00F8, 1'b0, 1'b0, 1'b1, 0, 4, 0, 1'b0, 0, 3);
        chk(oe_log[2] == 1'b1, "R8", "data_oe before drop", int'(oe_log[2]), 1);
        chk(oe_log[3] == 1'b0, "R8", "data_oe after drop", int'(oe_log[3]), 0);
        chk(acks == 0, "R8", "ready-out while floated", acks, 0);

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "acknowledges still expected", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule